// File: doc/BRIEF.md
# I2C Bus Timing Generator

This block produces the clock and condition waveforms for the master side of an I2C bus. It places every edge of the SCL and SDA lines a fixed number of system clock cycles after the previous one. A byte sequencer above it asks for one bus action at a time: a START, a STOP, the transmission of one bit, or the reception of one bit. The block drives the two open-drain lines through pull-down enables. A 1 on an enable means the line is pulled low, and a 0 means it is released. When the action finishes, the block pulses `done` for one cycle and goes back to waiting.

Four counts are supplied by the integrator, all measured in system clock cycles:
- **Period count:** the clock frequency divided by the bus rate. The bus rate is above zero and at most 400 kHz, with 100 kHz as the usual default.
- **Low count:** normally 5/9 of the period. The high part of each bit is the period minus the low count.
- **Condition count:** normally half the period. It sets the START hold time, the repeated-START setup time and the STOP setup time.
- **Data setup count:** normally 1/16 of the period. It sets how long SDA is stable before SCL rises.

With these ratios, a 4.7 µs / 4.0 µs low/high pair is met at 100 kHz, and a 1.3 µs / 0.6 µs pair at 400 kHz. Legal ranges: low count at least 2, high part at least 1, condition count at least 1, data setup count between 1 and low count minus 1.

Timing below is given for back-to-back operation. This means the next request is already present in the cycle in which `done` is high, and that cycle counts as the first SCL-low cycle of the next action.

Top module: `i2c_tgen`

## Requirements
- R1: While reset is held and after it is released, `scl_oe`, `sda_oe`, `done` and `rbit_val` are all 0 until a request is accepted.
- R2: For a bit action, SCL is held low for exactly `cfg_low` cycles (counting the cycle where the request is seen) and is then released for exactly `cfg_period - cfg_low` cycles. It is pulled low again in the cycle where `done` is high.
- R3: For a transmitted bit, `sda_oe` takes the inverted bit value (1 drives a 0 onto the bus) exactly `cfg_dsu` cycles before SCL is released. Before that it keeps its previous value, and afterwards it holds until `done`.
- R4: For a received bit, `sda_oe` becomes 0 `cfg_dsu` cycles before SCL is released. `rbit_val` takes the value `sda_in` has at the clock edge where SCL is released, and holds it afterwards.
- R5: `done` is high for exactly one cycle at the end of every action and never in two consecutive cycles.
- R6: A START requested while SCL is released pulls SDA low `cfg_cond` cycles after the accepting edge. It then pulls SCL low, with `done`, `cfg_cond` cycles later.
- R7: A START requested while SCL is held low (repeated START) releases SDA at once and releases SCL after `cfg_low` cycles. It pulls SDA low `cfg_cond` cycles later, then pulls SCL low with `done` after another `cfg_cond` cycles.
- R8: A STOP pulls SDA low at the accepting edge while SCL is low and releases SCL after `cfg_low` cycles. It releases SDA with `done` `cfg_cond` cycles later, leaving both lines released.
- R9: When several requests are present in the same idle cycle, exactly one is served, with priority START over STOP over transmit bit over receive bit.
- R10: Requests present while an action is in progress are ignored and leave no trace after that action ends.
- R11: While SCL is released, SDA only changes as a START (pulled low, action continues) or as a STOP (released, together with `done`).
- R12: With counts derived from a 125 MHz clock at 100 kHz and at 400 kHz, the measured SCL low and high times are at least 4.7/4.0 µs and 1.3/0.6 µs respectively.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_period | input | CW | Full SCL period in clock cycles |
| cfg_low | input | CW | SCL low part in clock cycles |
| cfg_cond | input | CW | START/STOP setup and hold count |
| cfg_dsu | input | CW | SDA-to-SCL-rise data setup count |
| req_start | input | 1 | Request a START or repeated START |
| req_stop | input | 1 | Request a STOP |
| req_wbit | input | 1 | Request transmission of one bit |
| wbit_val | input | 1 | Bit value to transmit |
| req_rbit | input | 1 | Request reception of one bit |
| sda_in | input | 1 | Sensed level of the SDA line |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| rbit_val | output | 1 | Last received bit |
| done | output | 1 | One-cycle end-of-action strobe |

## Verification
A corrupted phase register or counter appears at the lines within one action. An edge arrives one or more cycles early or late, `done` comes at the wrong cycle, or SDA moves while SCL is released. So each action's waveform is recorded and compared, edge by edge, against counts derived from the requirements. A mistake in the receive path shows only in `rbit_val` after `done`. For this reason, `sda_in` is flipped in the cycle right after the sampling edge, so that sampling one edge too early or too late gives the wrong value.

// File: rtl/i2c_tgen_pkg.sv
package i2c_tgen_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_RS_LO,
    PH_ST_SU,
    PH_ST_HD,
    PH_BIT_LO,
    PH_BIT_HI,
    PH_SP_LO,
    PH_SP_SU
  } phase_e;

endpackage

// File: rtl/i2c_tgen_cnt.sv
module i2c_tgen_cnt #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic [CW-1:0] cnt,
  output logic          cnt_zero
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - CW'(1);
    end
  end

  assign cnt_zero = (cnt == '0);

endmodule

// File: rtl/i2c_tgen_seq.sv
module i2c_tgen_seq
  import i2c_tgen_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cfg_period,
  input  logic [CW-1:0] cfg_low,
  input  logic [CW-1:0] cfg_cond,
  input  logic [CW-1:0] cfg_dsu,
  input  logic          req_start,
  input  logic          req_stop,
  input  logic          req_wbit,
  input  logic          wbit_val,
  input  logic          req_rbit,
  input  logic          sda_in,
  input  logic [CW-1:0] cnt,
  input  logic          cnt_zero,
  output logic          load,
  output logic [CW-1:0] load_val,
  output logic          scl_oe,
  output logic          sda_oe,
  output logic          rbit_val,
  output logic          done,
  output logic          busy,
  output logic          accept
);

  // Low phase is entered one cycle late (the done cycle counts as low)
  function automatic logic [CW-1:0] low_load(input logic [CW-1:0] lo);
    return lo - CW'(2);
  endfunction

  function automatic logic [CW-1:0] high_load(input logic [CW-1:0] per,
                                              input logic [CW-1:0] lo);
    return per - lo - CW'(1);
  endfunction

  function automatic logic [CW-1:0] cond_load(input logic [CW-1:0] cc);
    return cc - CW'(1);
  endfunction

  // Data setup reaching back to the accepting edge: update SDA there
  function automatic logic dsu_early(input logic [CW-1:0] lo,
                                     input logic [CW-1:0] ds);
    return ({1'b0, ds} + (CW+1)'(1)) >= {1'b0, lo};
  endfunction

  phase_e ph_q, ph_n;
  logic   scl_q, scl_n, sda_q, sda_n, rbit_q, rbit_n, done_n;
  logic   wr_q, wv_q, bit_acc, any_req;

  assign any_req = req_start | req_stop | req_wbit | req_rbit;
  assign accept  = (ph_q == PH_IDLE) && any_req;
  assign bit_acc = accept && !req_start && !req_stop;
  assign busy    = (ph_q != PH_IDLE);

  always_comb begin
    ph_n     = ph_q;
    load     = 1'b0;
    load_val = '0;
    scl_n    = scl_q;
    sda_n    = sda_q;
    rbit_n   = rbit_q;
    done_n   = 1'b0;
    unique case (ph_q)
      PH_IDLE: begin
        if (accept) begin
          load = 1'b1;
          if (req_start) begin
            sda_n = 1'b0;
            if (scl_q) begin
              ph_n     = PH_RS_LO;
              load_val = low_load(cfg_low);
            end else begin
              ph_n     = PH_ST_SU;
              load_val = cond_load(cfg_cond);
            end
          end else if (req_stop) begin
            ph_n     = PH_SP_LO;
            load_val = low_load(cfg_low);
            scl_n    = 1'b1;
            sda_n    = 1'b1;
          end else begin
            ph_n     = PH_BIT_LO;
            load_val = low_load(cfg_low);
            scl_n    = 1'b1;
            if (dsu_early(cfg_low, cfg_dsu)) sda_n = req_wbit ? !wbit_val : 1'b0;
          end
        end
      end
      PH_RS_LO: if (cnt_zero) begin
        scl_n = 1'b0; ph_n = PH_ST_SU; load = 1'b1; load_val = cond_load(cfg_cond);
      end
      PH_ST_SU: if (cnt_zero) begin
        sda_n = 1'b1; ph_n = PH_ST_HD; load = 1'b1; load_val = cond_load(cfg_cond);
      end
      PH_ST_HD: if (cnt_zero) begin
        scl_n = 1'b1; done_n = 1'b1; ph_n = PH_IDLE;
      end
      PH_BIT_LO: begin
        if (cnt == cfg_dsu) sda_n = wr_q ? !wv_q : 1'b0;
        if (cnt_zero) begin
          scl_n    = 1'b0;
          rbit_n   = sda_in;
          ph_n     = PH_BIT_HI;
          load     = 1'b1;
          load_val = high_load(cfg_period, cfg_low);
        end
      end
      PH_BIT_HI: if (cnt_zero) begin
        scl_n = 1'b1; done_n = 1'b1; ph_n = PH_IDLE;
      end
      PH_SP_LO: if (cnt_zero) begin
        scl_n = 1'b0; ph_n = PH_SP_SU; load = 1'b1; load_val = cond_load(cfg_cond);
      end
      PH_SP_SU: if (cnt_zero) begin
        sda_n = 1'b0; done_n = 1'b1; ph_n = PH_IDLE;
      end
      default: ph_n = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      scl_q  <= 1'b0;
      sda_q  <= 1'b0;
      rbit_q <= 1'b0;
      done   <= 1'b0;
      wr_q   <= 1'b0;
      wv_q   <= 1'b0;
    end else begin
      ph_q   <= ph_n;
      scl_q  <= scl_n;
      sda_q  <= sda_n;
      rbit_q <= rbit_n;
      done   <= done_n;
      if (bit_acc) begin
        wr_q <= req_wbit;
        wv_q <= wbit_val;
      end
    end
  end

  assign scl_oe   = scl_q;
  assign sda_oe   = sda_q;
  assign rbit_val = rbit_q;

endmodule

// File: rtl/i2c_tgen.sv
module i2c_tgen #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cfg_period,
  input  logic [CW-1:0] cfg_low,
  input  logic [CW-1:0] cfg_cond,
  input  logic [CW-1:0] cfg_dsu,
  input  logic          req_start,
  input  logic          req_stop,
  input  logic          req_wbit,
  input  logic          wbit_val,
  input  logic          req_rbit,
  input  logic          sda_in,
  output logic          scl_oe,
  output logic          sda_oe,
  output logic          rbit_val,
  output logic          done
);

  logic          load;
  logic [CW-1:0] load_val;
  logic [CW-1:0] cnt;
  logic          cnt_zero;
  logic          busy;
  logic          accept;

  i2c_tgen_cnt #(.CW(CW)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_val (load_val),
    .cnt      (cnt),
    .cnt_zero (cnt_zero)
  );

  i2c_tgen_seq #(.CW(CW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_period (cfg_period),
    .cfg_low    (cfg_low),
    .cfg_cond   (cfg_cond),
    .cfg_dsu    (cfg_dsu),
    .req_start  (req_start),
    .req_stop   (req_stop),
    .req_wbit   (req_wbit),
    .wbit_val   (wbit_val),
    .req_rbit   (req_rbit),
    .sda_in     (sda_in),
    .cnt        (cnt),
    .cnt_zero   (cnt_zero),
    .load       (load),
    .load_val   (load_val),
    .scl_oe     (scl_oe),
    .sda_oe     (sda_oe),
    .rbit_val   (rbit_val),
    .done       (done),
    .busy       (busy),
    .accept     (accept)
  );

endmodule

// File: rtl/i2c_tgen_chk.sv
module i2c_tgen_chk (
  input logic clk,
  input logic rst_n,
  input logic req_start,
  input logic req_stop,
  input logic req_wbit,
  input logic req_rbit,
  input logic scl_oe,
  input logic sda_oe,
  input logic done,
  input logic busy,
  input logic accept,
  input logic cnt_zero
);

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R5

  AST_SDA_COND_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(scl_oe) && !scl_oe && (sda_oe != $past(sda_oe))) |-> (sda_oe ? busy : done)); // R11

  AST_STOP_FREES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !scl_oe) |-> !sda_oe); // R8

  AST_SCL_PULL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_oe) |-> ($past(accept) || $past(cnt_zero && busy))); // R2

  AST_START_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_start || req_stop || req_wbit || req_rbit)); // R10

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy)); // R5

endmodule

bind i2c_tgen i2c_tgen_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_start (req_start),
  .req_stop  (req_stop),
  .req_wbit  (req_wbit),
  .req_rbit  (req_rbit),
  .scl_oe    (scl_oe),
  .sda_oe    (sda_oe),
  .done      (done),
  .busy      (busy),
  .accept    (accept),
  .cnt_zero  (cnt_zero)
);

// File: tb/sim_i2c_tgen.sv
module sim_i2c_tgen;
  localparam int CW = 16;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n;
  logic [CW-1:0] cfg_period, cfg_low, cfg_cond, cfg_dsu;
  logic          req_start, req_stop, req_wbit, wbit_val, req_rbit, sda_in;
  logic          scl_oe, sda_oe, rbit_val, done;

  i2c_tgen #(.CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .cfg_period(cfg_period), .cfg_low(cfg_low), .cfg_cond(cfg_cond), .cfg_dsu(cfg_dsu),
    .req_start(req_start), .req_stop(req_stop), .req_wbit(req_wbit),
    .wbit_val(wbit_val), .req_rbit(req_rbit), .sda_in(sda_in),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .rbit_val(rbit_val), .done(done)
  );

  int n_chk = 0, n_bad = 0;
  int L, H, C, D;
  logic tr_scl [0:4095];
  logic tr_sda [0:4095];
  int tr_n;

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", r, act, exp);
    end
  endtask

  task automatic chk_eq(input string r, input int act, input int exp);
    chk(act == exp, r, act, exp);
  endtask

  function automatic int first_idx(input bit on_scl, input int from, input bit val);
    for (int k = from; k <= tr_n; k++) begin
      if ((on_scl ? tr_scl[k] : tr_sda[k]) == val) return k;
    end
    return -1;
  endfunction

  function automatic bit steady(input bit on_scl, input int a, input int b, input bit val);
    for (int k = a; k <= b; k++) begin
      if ((on_scl ? tr_scl[k] : tr_sda[k]) != val) return 1'b0;
    end
    return 1'b1;
  endfunction

  task automatic set_cfg(input int lo, input int hi, input int cc, input int ds);
    L = lo; H = hi; C = cc; D = ds;
    cfg_low = CW'(lo); cfg_period = CW'(lo + hi); cfg_cond = CW'(cc); cfg_dsu = CW'(ds);
  endtask

  // rq bits: 0 start, 1 stop, 2 transmit bit, 3 receive bit. Called at a negedge.
  task automatic run_op(input logic [3:0] rq, input bit v, input bit rv, input bit poke);
    int k;
    req_start = rq[0]; req_stop = rq[1]; req_wbit = rq[2]; req_rbit = rq[3];
    wbit_val = v; sda_in = !rv;
    tr_scl[0] = scl_oe; tr_sda[0] = sda_oe;
    k = 0; tr_n = -1;
    while (tr_n < 0 && k < 4000) begin
      @(negedge clk);
      k++;
      if (k == 1) begin
        req_start = 1'b0; req_stop = 1'b0; req_wbit = 1'b0; req_rbit = 1'b0;
      end
      if (poke && k == 2) begin req_stop = 1'b1; req_start = 1'b1; end
      if (poke && k == 3) begin req_stop = 1'b0; req_start = 1'b0; end
      tr_scl[k] = scl_oe; tr_sda[k] = sda_oe;
      if (done) tr_n = k;
      if (k == L - 1) sda_in = rv;
      if (k == L) sda_in = !rv;
    end
    if (tr_n < 0) begin
      chk(1'b0, "R5 done missing (watchdog)", k, 0);
      tr_n = k;
    end
  endtask

  task automatic chk_bit(input bit wr, input bit v, input bit rv);
    int idx;
    idx = L - D;
    chk(steady(1'b1, 0, L - 1, 1'b1), "R2 SCL low phase", first_idx(1'b1, 0, 1'b0), L);
    chk_eq("R2 SCL low length", first_idx(1'b1, 0, 1'b0), L);
    chk_eq("R2 SCL high length", tr_n - L, H);
    chk(steady(1'b1, L, tr_n - 1, 1'b0) && tr_scl[tr_n], "R2 SCL pulled low at done", tr_scl[tr_n], 1);
    chk(steady(1'b0, 0, idx - 1, tr_sda[0]), "R3/R4 SDA held before setup point", tr_sda[idx-1], tr_sda[0]);
    if (wr) begin
      chk(steady(1'b0, idx, tr_n, !v), "R3 SDA value over setup and high", tr_sda[idx], !v);
    end else begin
      chk(steady(1'b0, idx, tr_n, 1'b0), "R4 SDA released for receive", tr_sda[idx], 0);
      chk_eq("R4 sampled bit", rbit_val, rv);
    end
  endtask

  task automatic chk_start_idle();
    chk_eq("R6 SDA falls after setup", first_idx(1'b0, 0, 1'b1), C + 1);
    chk_eq("R6 done after hold", tr_n, 2 * C + 1);
    chk(steady(1'b1, 0, tr_n - 1, 1'b0) && tr_scl[tr_n] && tr_sda[tr_n], "R6 SCL low at end", tr_scl[tr_n], 1);
  endtask

  task automatic chk_restart();
    chk_eq("R7 SDA released first", tr_sda[1], 0);
    chk_eq("R7 SCL release", first_idx(1'b1, 0, 1'b0), L);
    chk_eq("R7 SDA falls after setup", first_idx(1'b0, L, 1'b1), L + C);
    chk_eq("R7 done after hold", tr_n, L + 2 * C);
    chk(steady(1'b1, L, tr_n - 1, 1'b0) && tr_scl[tr_n], "R7 SCL low at end", tr_scl[tr_n], 1);
  endtask

  task automatic chk_stop();
    chk_eq("R8 SDA low while SCL low", tr_sda[1] & tr_scl[1], 1);
    chk_eq("R8 SCL release", first_idx(1'b1, 0, 1'b0), L);
    chk_eq("R8 done after setup", tr_n, L + C);
    chk(steady(1'b0, 1, tr_n - 1, 1'b1) && !tr_sda[tr_n] && !tr_scl[tr_n], "R8 bus free", tr_sda[tr_n], 0);
  endtask

  task automatic do_bit(input bit wr, input bit v, input bit rv);
    run_op(wr ? 4'b0100 : 4'b1000, v, rv, 1'b0);
    chk_bit(wr, v, rv);
  endtask

  task automatic speed_check(input int rate, input int lo_ns, input int hi_ns, input string tag);
    int per;
    per = 125_000_000 / rate;
    set_cfg((per * 5) / 9, per - (per * 5) / 9, per / 2, per / 16);
    run_op(4'b0001, 1'b0, 1'b0, 1'b0); chk_start_idle();
    do_bit(1'b1, 1'b1, 1'b0);
    chk(first_idx(1'b1, 0, 1'b0) * 8 >= lo_ns, {tag, " R12 low time ns"}, first_idx(1'b1, 0, 1'b0) * 8, lo_ns);
    chk((tr_n - first_idx(1'b1, 0, 1'b0)) * 8 >= hi_ns, {tag, " R12 high time ns"},
        (tr_n - first_idx(1'b1, 0, 1'b0)) * 8, hi_ns);
    run_op(4'b0010, 1'b0, 1'b0, 1'b0); chk_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int nb;
    bit b, r;
    void'($urandom(32'd1234));
    rst_n = 1'b0;
    req_start = 0; req_stop = 0; req_wbit = 0; wbit_val = 0; req_rbit = 0; sda_in = 1;
    set_cfg(4, 3, 2, 1);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk_eq("R1 reset outputs", {scl_oe, sda_oe, done, rbit_val}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk_eq("R1 idle after reset", {scl_oe, sda_oe, done, rbit_val}, 0);

    // directed sequence
    run_op(4'b0001, 0, 0, 0); chk_start_idle();
    do_bit(1, 0, 0); do_bit(1, 1, 0); do_bit(0, 0, 1); do_bit(0, 0, 0);
    run_op(4'b0001, 0, 0, 0); chk_restart();
    do_bit(1, 0, 0);
    run_op(4'b0010, 0, 0, 0); chk_stop();

    // R9 priority
    run_op(4'b0001, 0, 0, 0); chk_start_idle();
    do_bit(1, 1, 0);
    run_op(4'b0111, 0, 0, 0); chk_restart();          // R9 start wins
    do_bit(1, 1, 0);
    run_op(4'b1110, 0, 0, 0); chk_stop();             // R9 stop wins
    run_op(4'b0001, 0, 0, 0); chk_start_idle();
    run_op(4'b1100, 0, 1, 0); chk_bit(1, 0, 1);       // R9 transmit over receive

    // R10 requests during an action are ignored
    run_op(4'b0100, 1, 0, 1); chk_bit(1, 1, 0);
    begin
      bit seen;
      logic sda_keep;
      seen = 0; sda_keep = sda_oe;
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        if (done || !scl_oe || sda_oe != sda_keep) seen = 1;
      end
      chk_eq("R10 no action after ignored request", seen, 0);
    end
    run_op(4'b0010, 0, 0, 0); chk_stop();

    // corner: minimum counts, setup reaching the accepting edge
    set_cfg(2, 1, 1, 1);
    run_op(4'b0001, 0, 0, 0); chk_start_idle();
    do_bit(1, 0, 0); do_bit(0, 0, 1); do_bit(1, 1, 0);
    run_op(4'b0001, 0, 0, 0); chk_restart();
    run_op(4'b0010, 0, 0, 0); chk_stop();
    set_cfg(9, 2, 3, 8);
    run_op(4'b0001, 0, 0, 0); chk_start_idle();
    do_bit(1, 0, 0); do_bit(0, 0, 0); do_bit(1, 0, 0);
    run_op(4'b0010, 0, 0, 0); chk_stop();

    // constrained random
    for (int g = 0; g < 25; g++) begin
      int lo;
      lo = 2 + int'($urandom % 14);
      set_cfg(lo, 1 + int'($urandom % 12), 1 + int'($urandom % 10), 1 + int'($urandom % (lo - 1)));
      repeat (1 + ($urandom % 3)) @(negedge clk);
      run_op(4'b0001, 0, 0, 0); chk_start_idle();
      nb = 3 + int'($urandom % 4);
      for (int i = 0; i < nb; i++) begin
        b = 1'($urandom); r = 1'($urandom);
        do_bit(1'($urandom), b, r);
        if (i == 1 && ($urandom % 2) == 1) begin
          run_op(4'b0001, 0, 0, 0); chk_restart();
        end
      end
      run_op(4'b0010, 0, 0, 0); chk_stop();
    end

    // R12 standard and fast rates at 125 MHz
    speed_check(100_000, 4700, 4000, "100k");
    speed_check(400_000, 1300, 600, "400k");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule